// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable stand-in for a small serial EEPROM with 16-bit words. It is meant to sit in a test system as the device at the far end of a host's serial EEPROM driver. The host drives chip select, a serial clock and a data line. The model answers on a data-out line. All four pins are oversampled by the system clock `clk_i`, so the serial clock may be any rate well below it.

A command is made of four parts, in this order:
- a start bit of 1;
- a two-bit opcode;
- an address field of `ADDR_W` bits (6 or 8), MSB first;
- for the two write commands, 16 data bits.

Opcode `00` is an extended group, and the top two address bits choose its command. The array can be programmed only while a write-enable latch is set. Each programming command that takes effect starts a short busy period.

Top module: `seeprom_model`

## Requirements
- R1: After reset, with `cs_i` low, `dout_o` is 1, programming is disabled, and every word reads 16'hFFFF.
- R2: While `cs_i` is high, `din_i` is sampled on each rising edge of `sclk_i`. Zeros before the start bit are skipped. The start bit is followed by a two-bit opcode and then `ADDR_W` address bits, all MSB first.
- R3: READ (opcode 10). On the rising edge that carries the last address bit, `dout_o` goes to 0. The next 16 rising edges each present one bit of the word, D15 first. The edge after D0 returns `dout_o` to 1.
- R4: WRITE (opcode 01). The address is followed by 16 data bits, D15 first. The word is stored when programming is enabled.
- R5: ERASE (opcode 11) sets the addressed word to 16'hFFFF when programming is enabled.
- R6: Under opcode 00, top address bits 11 set the enable latch and 00 clear it. The remaining address bits are ignored.
- R7: Under opcode 00, top address bits 01 take 16 data bits and write them to every word when programming is enabled.
- R8: Under opcode 00, top address bits 10 set every word to 16'hFFFF when programming is enabled.
- R9: With programming disabled, WRITE, ERASE, write-all and erase-all leave the array unchanged and start no busy period.
- R10: Driving `cs_i` low aborts a partial command without effect. Within two `clk_i` cycles, `dout_o` is 1 and the decoder again waits for a start bit.
- R11: A programming command that takes effect starts a busy period of `BUSY_CYCLES` clocks. During it, while `cs_i` is high and no read is in progress, `dout_o` is 0 and no start bit is accepted. Once it ends, `dout_o` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, active high |
| sclk_i | input | 1 | Serial clock from the host |
| din_i | input | 1 | Serial command, address and data input |
| dout_o | output | 1 | Serial read data and ready/busy status; 1 when released |

## Verification
Each pin passes through one synchronizer flop and then acts at the next `clk_i` edge. A rising edge of `sclk_i`, or a change of `cs_i`, therefore shows up on `dout_o` two clock cycles later. An array update from a completed command is visible from that same edge onward. The bench holds each serial clock phase for four system clocks and reads `dout_o` at the end of the high phase, two cycles after the due edge. Busy checks are placed relative to the commit edge, early in a 40-cycle window and again well after it closes. After every command, chip select stays low for longer than the busy period before the next one begins.

// File: rtl/seeprom_pkg.sv
package seeprom_pkg;
  localparam int WORD_W = 16;
  localparam logic [WORD_W-1:0] ERASED_WORD = '1;

  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_DATA, ST_READ, ST_DONE
  } dec_state_e;

  localparam logic [1:0] OP_EXT   = 2'b00;
  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] OP_ERASE = 2'b11;

  localparam logic [1:0] EXT_PROG_OFF = 2'b00;
  localparam logic [1:0] EXT_FILL     = 2'b01;
  localparam logic [1:0] EXT_CLEAR    = 2'b10;
  localparam logic [1:0] EXT_PROG_ON  = 2'b11;
endpackage

// File: rtl/seeprom_pin_sync.sv
module seeprom_pin_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_i,
  input  logic din_i,
  output logic cs_o,
  output logic din_o,
  output logic rise_o
);
  logic sclk_q, sclk_qq, cs_q, din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q  <= 1'b0;
      sclk_qq <= 1'b0;
      cs_q    <= 1'b0;
      din_q   <= 1'b0;
    end else begin
      sclk_q  <= sclk_i;
      sclk_qq <= sclk_q;
      cs_q    <= cs_i;
      din_q   <= din_i;
    end
  end

  assign cs_o   = cs_q;
  assign din_o  = din_q;
  assign rise_o = sclk_q & ~sclk_qq;
endmodule

// File: rtl/seeprom_word_array.sv
module seeprom_word_array
  import seeprom_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              we_i,
  input  logic              we_all_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [WORD_W-1:0] wr_data_i
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= ERASED_WORD;
    end else if (we_all_i) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= wr_data_i;
    end else if (we_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];

  // R7 / R8: a bulk write reaches both ends of the array
  a_r7_fill_reaches_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_all_i |=> (mem_q[0] == $past(wr_data_i)) && (mem_q[DEPTH-1] == $past(wr_data_i)));
endmodule

// File: rtl/seeprom_cmd_dec.sv
module seeprom_cmd_dec
  import seeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              din_i,
  input  logic              rise_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_data_i,
  output logic              we_o,
  output logic              we_all_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              prog_en_o,
  output logic              dout_o
);
  localparam int CNT_W  = $clog2(WORD_W + 1);
  localparam int BUSY_W = $clog2(BUSY_CYCLES + 1);

  dec_state_e        state_q, state_d;
  logic [1:0]        opc_q, opc_d;
  logic [ADDR_W-1:0] addr_q, addr_d, addr_nxt;
  logic [WORD_W-1:0] data_q, data_d, data_nxt;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BUSY_W-1:0] busy_q, busy_d;
  logic              en_q, en_d, dout_q, dout_d, commit;
  logic [1:0]        ext_now, ext_held;

  assign addr_nxt = {addr_q[ADDR_W-2:0], din_i};
  assign data_nxt = {data_q[WORD_W-2:0], din_i};
  assign ext_now  = addr_nxt[ADDR_W-1 -: 2];
  assign ext_held = addr_q[ADDR_W-1 -: 2];

  always_comb begin
    state_d   = state_q;
    opc_d     = opc_q;
    addr_d    = addr_q;
    data_d    = data_q;
    cnt_d     = cnt_q;
    en_d      = en_q;
    dout_d    = dout_q;
    we_o      = 1'b0;
    we_all_o  = 1'b0;
    wr_addr_o = addr_q;
    wr_data_o = data_nxt;
    commit    = 1'b0;

    if (!cs_i) begin
      state_d = ST_IDLE;
    end else if (rise_i) begin
      unique case (state_q)
        ST_IDLE: if (din_i && busy_q == '0) begin
          state_d = ST_OPC;
          cnt_d   = CNT_W'(1);
        end
        ST_OPC: begin
          opc_d = {opc_q[0], din_i};
          if (cnt_q == '0) begin
            state_d = ST_ADDR;
            cnt_d   = CNT_W'(ADDR_W - 1);
          end else cnt_d = cnt_q - 1'b1;
        end
        ST_ADDR: begin
          addr_d = addr_nxt;
          if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
          else begin
            state_d = ST_DONE;
            unique case (opc_q)
              OP_READ: begin
                data_d  = rd_data_i;
                dout_d  = 1'b0;                 // leading dummy bit
                cnt_d   = CNT_W'(WORD_W);
                state_d = ST_READ;
              end
              OP_WRITE: begin
                state_d = ST_DATA;
                cnt_d   = CNT_W'(WORD_W - 1);
              end
              OP_ERASE: if (en_q) begin
                we_o      = 1'b1;
                wr_addr_o = addr_nxt;
                wr_data_o = ERASED_WORD;
                commit    = 1'b1;
              end
              default: unique case (ext_now)
                EXT_PROG_ON:  en_d = 1'b1;
                EXT_PROG_OFF: en_d = 1'b0;
                EXT_CLEAR: if (en_q) begin
                  we_all_o  = 1'b1;
                  wr_data_o = ERASED_WORD;
                  commit    = 1'b1;
                end
                default: begin
                  state_d = ST_DATA;
                  cnt_d   = CNT_W'(WORD_W - 1);
                end
              endcase
            endcase
          end
        end
        ST_DATA: begin
          data_d = data_nxt;
          if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
          else begin
            state_d = ST_DONE;
            if (en_q) begin
              commit   = 1'b1;
              we_all_o = (opc_q == OP_EXT) && (ext_held == EXT_FILL);
              we_o     = (opc_q == OP_WRITE);
            end
          end
        end
        ST_READ: begin
          if (cnt_q != '0) begin
            dout_d = data_q[WORD_W-1];
            data_d = {data_q[WORD_W-2:0], 1'b0};
            cnt_d  = cnt_q - 1'b1;
          end else state_d = ST_DONE;
        end
        default: ;
      endcase
    end

    if (!cs_i) dout_d = 1'b1;
    else if (state_d != ST_READ) dout_d = !(commit || busy_q != '0);
  end

  always_comb begin
    busy_d = busy_q;
    if (commit) busy_d = BUSY_W'(BUSY_CYCLES);
    else if (busy_q != '0) busy_d = busy_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      opc_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      cnt_q   <= '0;
      busy_q  <= '0;
      en_q    <= 1'b0;
      dout_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      opc_q   <= opc_d;
      addr_q  <= addr_d;
      data_q  <= data_d;
      cnt_q   <= cnt_d;
      busy_q  <= busy_d;
      en_q    <= en_d;
      dout_q  <= dout_d;
    end
  end

  assign rd_addr_o = addr_nxt;
  assign prog_en_o = en_q;
  assign dout_o    = dout_q;

  a_r10_cs_low_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_i |=> dout_q && state_q == ST_IDLE);
  a_r3_dummy_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(state_q == ST_READ) |-> !dout_q);
  a_r11_busy_blocks_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q != '0 && state_q == ST_IDLE) |=> state_q == ST_IDLE);
  a_r11_busy_shows_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q > BUSY_W'(1) && cs_i && state_q != ST_READ) |=> !dout_q);
endmodule

// File: rtl/seeprom_model.sv
module seeprom_model
  import seeprom_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_i,
  input  logic sclk_i,
  input  logic din_i,
  output logic dout_o
);
  logic              cs_s, din_s, rise_s;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [WORD_W-1:0] rd_data, wr_data;
  logic              we, we_all, prog_en;

  seeprom_pin_sync u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_i, .din_i,
    .cs_o(cs_s), .din_o(din_s), .rise_o(rise_s)
  );

  seeprom_cmd_dec #(.ADDR_W(ADDR_W), .BUSY_CYCLES(BUSY_CYCLES)) u_dec (
    .clk_i, .rst_ni, .cs_i(cs_s), .din_i(din_s), .rise_i(rise_s),
    .rd_addr_o(rd_addr), .rd_data_i(rd_data),
    .we_o(we), .we_all_o(we_all), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
    .prog_en_o(prog_en), .dout_o
  );

  seeprom_word_array #(.ADDR_W(ADDR_W)) u_array (
    .clk_i, .rst_ni, .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .we_i(we), .we_all_i(we_all), .wr_addr_i(wr_addr), .wr_data_i(wr_data)
  );

  a_r9_program_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we || we_all) |-> prog_en);
endmodule

// File: tb/seeprom_model_test.sv
module seeprom_model_test;
  localparam int AW   = 6;
  localparam int BUSY = 40;
  localparam int NW   = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, sclk = 1'b0, din = 1'b0;
  logic dout;
  int nvec = 0, nmis = 0;
  logic [15:0] model [NW];

  always #10 clk = ~clk;

  seeprom_model #(.ADDR_W(AW), .BUSY_CYCLES(BUSY)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .sclk_i(sclk), .din_i(din), .dout_o(dout)
  );

  function automatic logic [15:0] pat(input int a);
    return 16'((a * 16'h0409) ^ 16'h5A3C);
  endfunction

  task automatic wclk(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nvec++;
    if (act !== exp) begin
      nmis++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bit_io(input logic b, output logic so);
    din = b;
    wclk(4);
    sclk = 1'b1;
    wclk(4);
    so = dout;
    sclk = 1'b0;
  endtask

  task automatic cmd_end();
    sclk = 1'b0; cs = 1'b0; din = 1'b0;
    wclk(BUSY + 8);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [7:0] a, output logic last);
    logic s;
    cs = 1'b1;
    wclk(2);
    bit_io(1'b1, s);
    bit_io(op[1], s);
    bit_io(op[0], s);
    for (int i = AW - 1; i >= 0; i--) bit_io(a[i], s);
    last = s;
  endtask

  task automatic do_read(input int a, output logic [15:0] w, output logic dummy,
                         output logic after);
    logic s;
    hdr(2'b10, 8'(a), dummy);
    w = '0;
    for (int i = 0; i < 16; i++) begin
      bit_io(1'b0, s);
      w = {w[14:0], s};
    end
    bit_io(1'b0, after);
    cmd_end();
  endtask

  task automatic send_word(input logic [15:0] d, output logic last);
    logic s;
    for (int i = 15; i >= 0; i--) bit_io(d[i], s);
    last = s;
  endtask

  task automatic do_write(input int a, input logic [15:0] d, output logic last);
    logic s;
    hdr(2'b01, 8'(a), s);
    send_word(d, last);
    cmd_end();
  endtask

  function automatic logic [7:0] ext_addr(input logic [1:0] sel);
    return 8'({sel, {(AW-2){1'b0}}});
  endfunction

  task automatic check_word(input int a, input string tag);
    logic [15:0] w;
    logic d, af;
    do_read(a, w, d, af);
    chk(w, model[a], tag);
  endtask

  initial begin
    logic [15:0] w;
    logic d, af, s;
    for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
    wclk(5);
    chk({15'd0, dout}, 16'd1, "R1 dout released in reset");
    rst_n = 1'b1;
    wclk(3);
    chk({15'd0, dout}, 16'd1, "R1 dout idle after reset");

    // R1, R3: erased array, dummy zero, release after D0
    do_read(0, w, d, af);
    chk(w, 16'hFFFF, "R1 word 0 erased");
    chk({15'd0, d}, 16'd0, "R3 dummy bit");
    chk({15'd0, af}, 16'd1, "R3 released after D0");
    check_word(NW - 1, "R1 last word erased");

    // R9: write while disabled
    do_write(3, 16'h1357, s);
    chk({15'd0, s}, 16'd1, "R9 no busy when disabled");
    check_word(3, "R9 write ignored when disabled");

    // R6: enable, then R4 sweep of all addresses
    hdr(2'b00, ext_addr(2'b11), s);
    cmd_end();
    for (int a = 0; a < NW; a++) begin
      do_write(a, pat(a), s);
      model[a] = pat(a);
      chk({15'd0, s}, 16'd0, "R11 busy after write");
    end
    for (int a = 0; a < NW; a++) begin
      do_read(a, w, d, af);
      chk(w, model[a], "R4 R6 write sweep readback");
      chk({15'd0, d}, 16'd0, "R3 dummy bit per read");
    end

    // R2: leading zeros before start bit
    cs = 1'b1; wclk(2);
    bit_io(1'b0, s); bit_io(1'b0, s); bit_io(1'b0, s);
    bit_io(1'b1, s); bit_io(1'b1, s); bit_io(1'b0, s);
    for (int i = AW - 1; i >= 0; i--) bit_io(1'(9 >> i), s);
    w = '0;
    for (int i = 0; i < 16; i++) begin bit_io(1'b0, s); w = {w[14:0], s}; end
    cmd_end();
    chk(w, model[9], "R2 leading zeros skipped");

    // R5: erase one word, neighbour kept
    hdr(2'b11, 8'd10, s);
    cmd_end();
    model[10] = 16'hFFFF;
    check_word(10, "R5 erased word");
    check_word(11, "R5 neighbour kept");

    // R10: abort partial write, and abort mid-read
    hdr(2'b01, 8'd20, s);
    for (int i = 0; i < 8; i++) bit_io(1'b0, s);
    cs = 1'b0; sclk = 1'b0;
    wclk(3);
    chk({15'd0, dout}, 16'd1, "R10 dout released on abort");
    wclk(BUSY + 8);
    check_word(20, "R10 partial write no effect");
    hdr(2'b10, 8'd21, s);
    for (int i = 0; i < 5; i++) bit_io(1'b0, s);
    cs = 1'b0; sclk = 1'b0;
    wclk(3);
    chk({15'd0, dout}, 16'd1, "R10 dout released mid read");
    wclk(BUSY + 8);
    check_word(21, "R10 read after abort");

    // R11: busy visible on fresh select, then ready
    hdr(2'b01, 8'd30, s);
    send_word(16'hBEEF, s);
    model[30] = 16'hBEEF;
    cs = 1'b0; sclk = 1'b0;
    wclk(2);
    cs = 1'b1;
    wclk(4);
    chk({15'd0, dout}, 16'd0, "R11 busy on reselect");
    wclk(BUSY + 4);
    chk({15'd0, dout}, 16'd1, "R11 ready after busy");
    cmd_end();
    check_word(30, "R4 word after busy");

    // R7: write-all
    hdr(2'b00, ext_addr(2'b01), s);
    send_word(16'hC3A5, s);
    cmd_end();
    for (int i = 0; i < NW; i++) model[i] = 16'hC3A5;
    check_word(0, "R7 fill word 0");
    check_word(37, "R7 fill word 37");
    check_word(NW - 1, "R7 fill last word");

    // R8: erase-all
    hdr(2'b00, ext_addr(2'b10), s);
    cmd_end();
    for (int i = 0; i < NW; i++) model[i] = 16'hFFFF;
    check_word(0, "R8 clear word 0");
    check_word(NW - 1, "R8 clear last word");

    // R6: disable, then R9 programming ignored
    hdr(2'b00, ext_addr(2'b00), s);
    cmd_end();
    do_write(5, 16'h0F0F, s);
    chk({15'd0, s}, 16'd1, "R9 no busy after disable");
    check_word(5, "R6 write blocked after disable");
    hdr(2'b00, ext_addr(2'b01), s);
    send_word(16'h0000, s);
    cmd_end();
    check_word(44, "R9 fill blocked");

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nmis++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nmis);
    $finish;
  end
endmodule